// File: doc/BRIEF.md
# Fractional Clock Divider with Stop Handshake

This block derives an output clock from one of four source inputs by dividing it by a programmable fixed-point ratio. The ratio word has twelve integer bits over twelve fractional bits. An instance keeps only a parameterised slice of that word. The fractional part is spread over time by a phase accumulator: each output period lasts either the integer count or one source tick more. Over a long run the average ratio therefore equals the programmed value.

The block runs on one system clock. Each source is presented as a one-cycle tick strobe in that clock domain, and the output is a level that changes only on ticks of the selected source. A `busy` flag shows whether the divider is running. Software clears the enable bit and then polls `busy` until it falls. Only then is the divider truly stopped, always with the output low. The divisor and source choice are copied into a shadow when the divider starts, so writes made while it runs wait for the next start. A parameter can mark an instance as never stopping.

Top module: `frac_clkgen`

## Requirements
- R1: The implemented divisor is `div_word[12+INT_BITS-1 : 12-FRAC_BITS]`, with integer part `div_word[12 +: INT_BITS]` and fraction `div_word[12-FRAC_BITS +: FRAC_BITS]`. All other bits of `div_word` have no effect on the output.
- R2: With integer part I and fraction F, period k (k = 1, 2, ...) counted from a start lasts I + floor(k*F/2^FRAC_BITS) - floor((k-1)*F/2^FRAC_BITS) selected-source ticks.
- R3: Each period is low first and high for its last floor(I/2) ticks. The output falls on the tick that ends the period.
- R4: When the implemented divisor is zero the divider does not start: `busy` and `clk_out` stay low.
- R5: An integer part of 0 or 1 is used as 2.
- R6: From idle, with enable (or the always-running parameter) set and a nonzero divisor, `busy` is high after the next clock edge.
- R7: After enable is cleared, `busy` stays high until the current period ends and then falls in the same cycle as `clk_out`. No high phase is ever cut short.
- R8: `div_word` and `src_sel` are sampled only while `busy` is low. Changes made while busy take effect at the next start.
- R9: `src_sel` picks the tick source: 0 is a constant ground with no ticks, 1 is the crystal tick, 2 is test tick 0, 3 is test tick 1. With ground selected, a running divider never completes a period.
- R10: With ALWAYS_ON = 1 the divider starts and keeps running with `enable` low.
- R11: After reset, `busy` and `clk_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run request |
| src_sel | input | 2 | Source index |
| div_word | input | 24 | 12.12 fixed-point divisor |
| xosc_tick | input | 1 | Crystal source tick |
| test0_tick | input | 1 | Test source 0 tick |
| test1_tick | input | 1 | Test source 1 tick |
| clk_out | output | 1 | Divided output level |
| busy | output | 1 | Divider running flag |

## Verification
The bench builds two instances with INT_BITS = 3 and FRAC_BITS = 2, one stoppable and one with ALWAYS_ON = 1. With five implemented bits, every divisor value 0 to 31 is swept. Each value is combined with junk in all unimplemented bits and with a rotating source at tick spacings of 1, 2 and 3 cycles. Four consecutive periods span the full fraction cycle, so every stretch pattern and the clamp of small integer parts can be checked against an arithmetic model. Directed cases cover a disable in mid-period, writes made while running, the ground source and the never-stopping instance.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int DIV_W      = 24;
    localparam int DIV_FRAC_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } fcg_state_e;

    typedef enum logic [1:0] {
        SRC_GND   = 2'd0,
        SRC_XOSC  = 2'd1,
        SRC_TEST0 = 2'd2,
        SRC_TEST1 = 2'd3
    } fcg_src_e;
endpackage

// File: rtl/fcg_field_decode.sv
module fcg_field_decode
    import fcg_pkg::*;
#(
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4
) (
    input  logic [DIV_W-1:0]     word_i,
    output logic [INT_BITS-1:0]  int_eff_o,
    output logic [FRAC_BITS-1:0] frac_o,
    output logic                 zero_o
);
    localparam int LSB    = DIV_FRAC_W - FRAC_BITS;
    localparam int IMPL_W = INT_BITS + FRAC_BITS;

    logic [IMPL_W-1:0]   impl;
    logic [INT_BITS-1:0] int_raw;
    logic                word_unused;

    assign impl        = word_i[LSB +: IMPL_W];
    assign int_raw     = impl[IMPL_W-1 -: INT_BITS];
    assign frac_o      = impl[FRAC_BITS-1:0];
    assign zero_o      = (impl == '0);
    // integer parts below two would leave no high or no low phase
    assign int_eff_o   = (int_raw < INT_BITS'(2)) ? INT_BITS'(2) : int_raw;
    assign word_unused = ^word_i;
endmodule

// File: rtl/fcg_src_mux.sv
module fcg_src_mux
    import fcg_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       xosc_i,
    input  logic       test0_i,
    input  logic       test1_i,
    output logic       tick_o
);
    always_comb begin
        unique case (fcg_src_e'(sel_i))
            SRC_GND:   tick_o = 1'b0;
            SRC_XOSC:  tick_o = xosc_i;
            SRC_TEST0: tick_o = test0_i;
            SRC_TEST1: tick_o = test1_i;
            default:   tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcg_phase_acc.sv
module fcg_phase_acc #(
    parameter int FRAC_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 step_i,
    input  logic [FRAC_BITS-1:0] frac_i,
    output logic                 carry_o
);
    logic [FRAC_BITS-1:0] acc;
    logic [FRAC_BITS:0]   sum;

    assign sum     = {1'b0, acc} + {1'b0, frac_i};
    assign carry_o = sum[FRAC_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc <= '0;
        else if (load_i) acc <= frac_i;
        else if (step_i) acc <= sum[FRAC_BITS-1:0];
    end
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
    import fcg_pkg::*;
#(
    parameter int   INT_BITS  = 4,
    parameter int   FRAC_BITS = 4,
    parameter logic ALWAYS_ON = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [1:0]  src_sel,
    input  logic [23:0] div_word,
    input  logic        xosc_tick,
    input  logic        test0_tick,
    input  logic        test1_tick,
    output logic        clk_out,
    output logic        busy
);
    localparam int CNT_W = INT_BITS + 1;

    fcg_state_e           state, nxt;
    logic [DIV_W-1:0]     sh_word;
    logic [1:0]           sh_sel;
    logic [CNT_W-1:0]     cnt, len;
    logic [INT_BITS-1:0]  live_int, run_int, half;
    logic [FRAC_BITS-1:0] live_frac, run_frac, acc_frac;
    logic                 live_zero, run_zero_unused;
    logic                 sel_tick, go, start, wrap, renew, carry;

    fcg_field_decode #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_live_dec (
        .word_i(div_word), .int_eff_o(live_int), .frac_o(live_frac), .zero_o(live_zero));

    fcg_field_decode #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_run_dec (
        .word_i(sh_word), .int_eff_o(run_int), .frac_o(run_frac), .zero_o(run_zero_unused));

    fcg_src_mux u_mux (
        .sel_i(sh_sel), .xosc_i(xosc_tick), .test0_i(test0_tick),
        .test1_i(test1_tick), .tick_o(sel_tick));

    assign go       = ALWAYS_ON | enable;
    assign start    = (state == ST_IDLE) && go && !live_zero;
    assign wrap     = (cnt == len - CNT_W'(1));
    assign renew    = (state == ST_RUN) && sel_tick && wrap && go;
    assign acc_frac = (state == ST_IDLE) ? live_frac : run_frac;
    assign half     = run_int >> 1;

    fcg_phase_acc #(.FRAC_BITS(FRAC_BITS)) u_acc (
        .clk(clk), .rst_n(rst_n), .load_i(start), .step_i(renew),
        .frac_i(acc_frac), .carry_o(carry));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_RUN;
            ST_RUN: begin
                if (sel_tick && wrap) nxt = go ? ST_RUN : ST_IDLE;
                else if (!go)         nxt = ST_DRAIN;
            end
            ST_DRAIN: if (sel_tick && wrap) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shadow and period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_word <= '0;
            sh_sel  <= '0;
            cnt     <= '0;
            len     <= '0;
        end else if (state == ST_IDLE) begin
            sh_word <= div_word;
            sh_sel  <= src_sel;
            cnt     <= '0;
            len     <= {1'b0, live_int};
        end else if (sel_tick) begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
            if (renew) len <= {1'b0, run_int} + CNT_W'(carry);
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        clk_out = busy && (cnt >= len - CNT_W'(half));
    end
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
    parameter int   INT_BITS  = 4,
    parameter int   FRAC_BITS = 4,
    parameter logic ALWAYS_ON = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic [23:0] div_word,
    input logic        busy,
    input logic        clk_out,
    input logic        sel_tick,
    input logic [23:0] sh_word,
    input logic [1:0]  sh_sel
);
    localparam int LSB    = 12 - FRAC_BITS;
    localparam int IMPL_W = INT_BITS + FRAC_BITS;

    logic                live_nz;
    logic [INT_BITS-1:0] sh_int, exp_half, high_ticks;
    logic                chk_unused;

    assign live_nz    = |div_word[LSB +: IMPL_W];
    assign sh_int     = sh_word[12 +: INT_BITS];
    assign exp_half   = ((sh_int < INT_BITS'(2)) ? INT_BITS'(2) : sh_int) >> 1;
    assign chk_unused = ^{div_word, sh_word};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                high_ticks <= '0;
        else if (!clk_out)         high_ticks <= '0;
        else if (sel_tick)         high_ticks <= high_ticks + INT_BITS'(1);
    end

    a_r3_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out) |-> (high_ticks == exp_half));

    a_r4_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !live_nz) |=> !busy);

    a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (enable || ALWAYS_ON) && live_nz) |=> busy);

    a_r7_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_tick) |=> busy);

    a_r7_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !clk_out);

    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(sh_word) && $stable(sh_sel)));

    a_r10_never_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (ALWAYS_ON && busy) |=> busy);
endmodule

bind frac_clkgen fcg_checker #(
    .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .ALWAYS_ON(ALWAYS_ON)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_word(div_word),
    .busy(busy), .clk_out(clk_out), .sel_tick(sel_tick),
    .sh_word(sh_word), .sh_sel(sh_sel)
);

// File: tb/frac_clkgen_tb_top.sv
module frac_clkgen_tb_top;
    localparam int IB = 3;
    localparam int FB = 2;
    localparam logic [23:0] JUNK = 24'hFF83FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  src_sel = 2'd1;
    logic [23:0] div_word = '0;
    logic        xosc_tick = 1'b1, test0_tick = 1'b0, test1_tick = 1'b0;
    logic        clk_out, busy, aon_out, aon_busy;
    int          n_run = 0, n_fail = 0, ph = 0;

    always #5 clk = ~clk;

    frac_clkgen #(.INT_BITS(IB), .FRAC_BITS(FB), .ALWAYS_ON(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
        .div_word(div_word), .xosc_tick(xosc_tick), .test0_tick(test0_tick),
        .test1_tick(test1_tick), .clk_out(clk_out), .busy(busy));

    frac_clkgen #(.INT_BITS(IB), .FRAC_BITS(FB), .ALWAYS_ON(1'b1)) dut_aon_i (
        .clk(clk), .rst_n(rst_n), .enable(1'b0), .src_sel(2'd1),
        .div_word(24'h005000), .xosc_tick(xosc_tick), .test0_tick(test0_tick),
        .test1_tick(test1_tick), .clk_out(aon_out), .busy(aon_busy));

    initial forever begin
        @(negedge clk);
        ph = ph + 1;
        test0_tick = (ph % 2 == 0);
        test1_tick = (ph % 3 == 0);
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // wait at negedges for a falling edge of clk_out; returns its cycle stamp
    task automatic wait_fall(output int stamp);
        logic prev = clk_out;
        stamp = -1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (prev && !clk_out) begin stamp = ph; return; end
            prev = clk_out;
        end
    endtask

    function automatic int exp_len(int ie, int f, int k);
        return ie + ((k * f) >> FB) - (((k - 1) * f) >> FB);
    endfunction

    task automatic run_case(input int d, input int sel);
        int i_raw = d >> FB, f = d & 3, ie, hf, s, bad_iv, bad_hi, t_prev, t_rise;
        logic prev;
        int nf;
        ie = (i_raw < 2) ? 2 : i_raw;
        hf = ie / 2;
        s = sel;
        @(negedge clk);
        div_word = (24'(d) << (12 - FB)) | JUNK;
        src_sel  = 2'(sel);
        enable   = 1'b1;
        if (d == 0) begin
            bad_iv = 0;
            repeat (20) begin
                @(negedge clk);
                if (busy || clk_out) bad_iv++;
            end
            check(bad_iv == 0, "R4 zero divisor runs", bad_iv, 0);
            enable = 1'b0;
            return;
        end
        prev = clk_out; nf = 0; bad_iv = 0; bad_hi = 0; t_prev = 0; t_rise = 0;
        for (int c = 0; c < 600 && nf < 6; c++) begin
            @(negedge clk);
            if (!prev && clk_out) t_rise = ph;
            if (prev && !clk_out) begin
                if (nf > 0 && (ph - t_prev) != exp_len(ie, f, nf + 1) * s) begin
                    bad_iv++;
                    $display("  d=%0d period %0d: %0d cycles, exp %0d", d, nf + 1,
                             ph - t_prev, exp_len(ie, f, nf + 1) * s);
                end
                if ((ph - t_rise) != hf * s) bad_hi++;
                t_prev = ph;
                nf++;
            end
            prev = clk_out;
        end
        check(nf == 6 && bad_iv == 0, "R1/R2/R5/R9 period sequence", bad_iv, 0);
        check(bad_hi == 0, "R3 high width", bad_hi, 0);
        enable = 1'b0;
        for (int c = 0; c < 60 && busy; c++) @(negedge clk);
        check(!busy && !clk_out, "R7 stopped low", int'(busy) + int'(clk_out), 0);
    endtask

    initial begin
        int t0, t1, highs;
        logic seen_hi, b5, b6;
        repeat (3) @(negedge clk);
        check(!busy && !clk_out, "R11 reset state", int'(busy) + int'(clk_out), 0);
        rst_n = 1'b1;

        // R6 and R7: busy rise and drain after mid-period disable
        @(negedge clk);
        div_word = 24'h006000; src_sel = 2'd1; enable = 1'b1;
        @(negedge clk);
        check(busy, "R6 busy after one edge", int'(busy), 1);
        wait_fall(t0);
        enable = 1'b0;
        highs = 0; b5 = 1'b0; b6 = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (clk_out) highs++;
            if (i == 5) b5 = busy;
            if (i == 6) b6 = busy | clk_out;
        end
        check(b5 && !b6, "R7 busy until period end", int'(b5), 1);
        check(highs == 3, "R7 full high phase on stop", highs, 3);

        // R8: writes while busy are held
        @(negedge clk);
        div_word = 24'h004000; src_sel = 2'd1; enable = 1'b1;
        wait_fall(t0);
        div_word = 24'h007000; src_sel = 2'd2;
        wait_fall(t0); wait_fall(t1);
        check(t1 - t0 == 4, "R8 held write not applied", t1 - t0, 4);
        enable = 1'b0;
        for (int c = 0; c < 40 && busy; c++) @(negedge clk);
        enable = 1'b1;
        wait_fall(t0); wait_fall(t1);
        check(t1 - t0 == 14, "R8 write applied at restart", t1 - t0, 14);
        enable = 1'b0;
        for (int c = 0; c < 40 && busy; c++) @(negedge clk);

        // R10: always-running instance with enable tied low
        @(negedge clk);
        seen_hi = aon_out;
        t0 = -1; t1 = -1;
        for (int c = 0; c < 40 && t1 < 0; c++) begin
            @(negedge clk);
            if (seen_hi && !aon_out) begin
                if (t0 < 0) t0 = ph; else t1 = ph;
            end
            seen_hi = aon_out;
        end
        check(aon_busy && (t1 - t0 == 5), "R10 runs with enable low", t1 - t0, 5);

        // exhaustive sweep of the implemented divisor, rotating sources
        for (int d = 0; d < 32; d++) run_case(d, 1 + (d % 3));

        // R9: ground source never completes a period
        @(negedge clk);
        div_word = 24'h004000; src_sel = 2'd0; enable = 1'b1;
        seen_hi = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (clk_out) seen_hi = 1'b1;
        end
        check(busy && !seen_hi, "R9 ground source", int'(seen_hi), 0);
        enable = 1'b0;
        repeat (10) @(negedge clk);
        check(busy, "R9 ground drain never ends", int'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !clk_out, "R11 reset clears", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule